// File: doc/BRIEF.md
# Calendar Clock Core with Deferred Register Commit

This core keeps the time of day (seconds, minutes, hours) and a calendar date (day, month, year offset, leap marker). A one-cycle enable pulse, arriving once per second from a slow timebase, moves the clock forward. Software reads and writes the core through a 32-bit word bus with three decoded locations: a status word, the date word and the time word.

A software write to the time or date word is not applied at once. The core holds the written value as a pending update and raises a busy bit in the status word. The pending value replaces the live register on the next second pulse, and the busy bit drops in that same cycle. Software polls the busy bit before it writes the other word. The counters keep running while an update is pending. There is no read snapshot, so a reader that wants a consistent pair of words must read until two passes agree.

The year is kept as a small offset from a fixed base. Whether February has 29 days depends on a leap marker that software supplies. The core does not work out the marker itself, and it never changes it.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the status, date and time words all read as zero.
- R2: The time word holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. On each pulse the seconds advance. A count of 59 wraps to 0 and carries into the minutes, minute 59 wraps into the hours, and hour 23 wraps to 0 and carries one day into the date.
- R3: In a cycle with no second pulse and no commit, neither the time nor the date changes.
- R4: The date word holds the day in bits [4:0] and the month (1 to 12) in bits [11:8]. A day carry on the last day of a month sets the day to 1 and moves the month up by one. Months 4, 6, 9 and 11 end on day 30, and the other months except 2 end on day 31.
- R5: The leap marker is date bit 22. Month 2 ends on day 29 when the marker is set and on day 28 when it is clear.
- R6: The year offset is date bits [21:16], six bits by default. A day carry on the last day of month 12 gives day 1 of month 1 and adds one to the year offset, which wraps from 63 to 0. The leap marker is left unchanged.
- R7: A time write sets status bit 8 from the next cycle and leaves the time unchanged. On the next pulse the written value appears and bit 8 clears in the same cycle.
- R8: A date write sets status bit 7 and commits on the next pulse in the same way as R7, with bit 7 clearing as the date value appears.
- R9: A pulse that arrives while an update is pending is still applied to the old value, including its day carry into the other register. The pending value then overwrites the result in the register being updated.
- R10: Writes to the status word or to an unmapped address change nothing, and reads of an unmapped address return zero.
- R11: A write that arrives in the same cycle as a pulse is not committed by that pulse. It stays pending until the following pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address: 0x0 status, 0x4 date, 0x8 time |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A counter that wraps at the wrong limit shows up on the time or date word at the first pulse that crosses that boundary. For that reason the directed cases park the clock one second before each rollover: minute, day, end of a 30-day or 31-day month, February in both leap settings, and the end of year 63. A staging slot that is lost or committed too early shows in status bits 7 and 8 one cycle after the write, or as a wrong value right after the next pulse. The random phase mixes writes, writes that coincide with a pulse, and plain pulses, and it compares all three words after every step.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int TIME_BUSY_BIT = 8;
   localparam int DATE_BUSY_BIT = 7;
   localparam int OFS_STATUS    = 'h0;
   localparam int OFS_DATE      = 'h4;
   localparam int OFS_TIME      = 'h8;

   typedef struct packed {
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } tod_t;

   // last day of a month; February follows the supplied leap marker
   function automatic logic [4:0] month_last(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                     return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
         default:                  return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_commit_slot.sv
module rtc_commit_slot #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         tick,
   output logic         busy,
   output logic         commit,
   output logic [W-1:0] staged
);
   // a write in a pulse cycle waits for the following pulse
   assign commit = tick && busy && !wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         staged <= '0;
      end else if (wr) begin
         busy   <= 1'b1;
         staged <= wdata;
      end else if (commit) begin
         busy   <= 1'b0;
      end
   end

   // R7
   busy_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr));
   // R8
   busy_clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));
   // R11
   write_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> busy);

endmodule

// File: rtl/rtc_tod_cnt.sv
module rtc_tod_cnt
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  tod_t load_val,
   output tod_t tod,
   output logic day_carry
);
   logic sec_wrap, min_wrap, hour_wrap;

   assign sec_wrap  = tod.sec  >= 6'd59;
   assign min_wrap  = tod.min  >= 6'd59;
   assign hour_wrap = tod.hour >= 5'd23;
   // carry is taken from the value before any pending load
   assign day_carry = tick && sec_wrap && min_wrap && hour_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tod <= '0;
      end else if (load) begin
         tod <= load_val;
      end else if (tick) begin
         if (!sec_wrap) begin
            tod.sec <= tod.sec + 6'd1;
         end else begin
            tod.sec <= '0;
            if (!min_wrap) begin
               tod.min <= tod.min + 6'd1;
            end else begin
               tod.min  <= '0;
               tod.hour <= hour_wrap ? 5'd0 : tod.hour + 5'd1;
            end
         end
      end
   end

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !load && sec_wrap |=> tod.sec == 6'd0);
   // R3
   tod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !load |=> $stable(tod));

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
   import rtc_cal_pkg::*;
#(
   parameter int YEAR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              load,
   input  logic [4:0]        ld_day,
   input  logic [3:0]        ld_mon,
   input  logic [YEAR_W-1:0] ld_year,
   input  logic              ld_leap,
   output logic [4:0]        day,
   output logic [3:0]        mon,
   output logic [YEAR_W-1:0] year,
   output logic              leap
);
   logic [4:0] last_day;
   logic       end_of_month;

   assign last_day     = month_last(mon, leap);
   assign end_of_month = day >= last_day;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         day  <= '0;
         mon  <= '0;
         year <= '0;
         leap <= 1'b0;
      end else if (load) begin
         day  <= ld_day;
         mon  <= ld_mon;
         year <= ld_year;
         leap <= ld_leap;
      end else if (inc) begin
         if (!end_of_month) begin
            day <= day + 5'd1;
         end else begin
            day <= 5'd1;
            if (mon >= 4'd12) begin
               mon  <= 4'd1;
               year <= year + 1'b1;
            end else begin
               mon  <= mon + 4'd1;
            end
         end
      end
   end

   // R5
   feb_common_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !load && mon == 4'd2 && day == 5'd28 && !leap |=> day == 5'd1 && mon == 4'd3);
   // R6
   year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !load && mon == 4'd12 && end_of_month |=>
         mon == 4'd1 && year == YEAR_W'($past(year) + 1'b1) && leap == $past(leap));
   // R3
   date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !load |=> $stable({day, mon, year, leap}));

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
   import rtc_cal_pkg::*;
#(
   parameter int YEAR_W = 6,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam int LEAP_BIT = 16 + YEAR_W;
   localparam int DATE_W   = 5 + 4 + YEAR_W + 1;
   localparam int TIME_W   = $bits(tod_t);
   localparam logic [31:0] USED_MASK =
      32'h001F_3F3F | 32'h0000_0F1F | ((32'h1 << (YEAR_W + 1)) - 32'h1) << 16;

   generate
      if (YEAR_W < 1 || YEAR_W > 9) begin : g_bad_year_w
         $error("YEAR_W must be 1..9 so the leap marker stays in the word");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W must reach the time word offset");
      end
   endgenerate

   logic              sel_time, sel_date;
   logic              busy_t, busy_d, commit_t, commit_d;
   logic [TIME_W-1:0] stg_t;
   logic [DATE_W-1:0] stg_d;
   tod_t              tod;
   logic              day_carry;
   logic [4:0]        d_day;
   logic [3:0]        d_mon;
   logic [YEAR_W-1:0] d_year;
   logic              d_leap;
   logic              unused_wdata;

   assign sel_time = bus_wr && (bus_addr == ADDR_W'(OFS_TIME));
   assign sel_date = bus_wr && (bus_addr == ADDR_W'(OFS_DATE));
   assign unused_wdata = ^(bus_wdata & ~USED_MASK);

   rtc_commit_slot #(.W(TIME_W)) u_slot_time (
      .clk(clk), .rst_n(rst_n), .wr(sel_time),
      .wdata({bus_wdata[20:16], bus_wdata[13:8], bus_wdata[5:0]}),
      .tick(tick), .busy(busy_t), .commit(commit_t), .staged(stg_t));

   rtc_commit_slot #(.W(DATE_W)) u_slot_date (
      .clk(clk), .rst_n(rst_n), .wr(sel_date),
      .wdata({bus_wdata[LEAP_BIT], bus_wdata[16 +: YEAR_W], bus_wdata[11:8], bus_wdata[4:0]}),
      .tick(tick), .busy(busy_d), .commit(commit_d), .staged(stg_d));

   rtc_tod_cnt u_tod (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(commit_t),
      .load_val(tod_t'(stg_t)), .tod(tod), .day_carry(day_carry));

   rtc_date_cnt #(.YEAR_W(YEAR_W)) u_date (
      .clk(clk), .rst_n(rst_n), .inc(day_carry), .load(commit_d),
      .ld_day(stg_d[4:0]), .ld_mon(stg_d[8:5]),
      .ld_year(stg_d[9 +: YEAR_W]), .ld_leap(stg_d[DATE_W-1]),
      .day(d_day), .mon(d_mon), .year(d_year), .leap(d_leap));

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_STATUS)) begin
         bus_rdata[TIME_BUSY_BIT] = busy_t;
         bus_rdata[DATE_BUSY_BIT] = busy_d;
      end else if (bus_addr == ADDR_W'(OFS_DATE)) begin
         bus_rdata[4:0]            = d_day;
         bus_rdata[11:8]           = d_mon;
         bus_rdata[16 +: YEAR_W]   = d_year;
         bus_rdata[LEAP_BIT]       = d_leap;
      end else if (bus_addr == ADDR_W'(OFS_TIME)) begin
         bus_rdata[5:0]            = tod.sec;
         bus_rdata[13:8]           = tod.min;
         bus_rdata[20:16]          = tod.hour;
      end
   end

   // R9
   carry_during_time_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      day_carry && commit_t && !commit_d && d_mon == 4'd1 && d_day == 5'd1 |=> d_day == 5'd2);
   // R7
   time_commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_t |=> !busy_t && tod == tod_t'($past(stg_t)));

endmodule

// File: tb/rtc_cal_core_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int failures = 0;

   // reference state
   int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_leap;
   bit pend_t, pend_d;
   logic [31:0] stg_t, stg_d;

   always #2.5 clk = ~clk;

   rtc_cal_core dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   function automatic int mlast(int mon, int leap);
      if (mon == 2) return leap ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] tword(int h, int m, int s);
      return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
   endfunction

   function automatic logic [31:0] dword(int d, int mo, int y, int lp);
      return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
   endfunction

   task automatic m_tick(bit hold_t, bit hold_d);
      bit carry = (m_sec >= 59 && m_min >= 59 && m_hr >= 23);
      if (m_sec >= 59) begin
         m_sec = 0;
         if (m_min >= 59) begin m_min = 0; m_hr = (m_hr >= 23) ? 0 : m_hr + 1; end
         else m_min++;
      end else m_sec++;
      if (carry) begin
         if (m_day >= mlast(m_mon, m_leap)) begin
            m_day = 1;
            if (m_mon >= 12) begin m_mon = 1; m_yr = (m_yr + 1) % 64; end
            else m_mon++;
         end else m_day++;
      end
      if (pend_t && !hold_t) begin
         m_sec = stg_t[5:0]; m_min = stg_t[13:8]; m_hr = stg_t[20:16]; pend_t = 0;
      end
      if (pend_d && !hold_d) begin
         m_day = stg_d[4:0]; m_mon = stg_d[11:8]; m_yr = stg_d[21:16]; m_leap = stg_d[22];
         pend_d = 0;
      end
   endtask

   task automatic m_write(logic [3:0] a, logic [31:0] d);
      if (a == 4'h8) begin pend_t = 1; stg_t = d; end
      if (a == 4'h4) begin pend_d = 1; stg_d = d; end
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic check_all(string tag);
      logic [31:0] v;
      rd(4'h0, v); check({tag, " status"}, v, (32'(pend_t) << 8) | (32'(pend_d) << 7));
      rd(4'h4, v); check({tag, " date"}, v, dword(m_day, m_mon, m_yr, m_leap));
      rd(4'h8, v); check({tag, " time"}, v, tword(m_hr, m_min, m_sec));
   endtask

   // one bus cycle; optionally a pulse in the same cycle
   task automatic cyc(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
      @(negedge clk);
      bus_wr = 0; tick = 0;
      if (tk) m_tick(wr && a == 4'h8, wr && a == 4'h4);
      if (wr) m_write(a, d);
   endtask

   task automatic pulse(); cyc(0, 4'h0, 0, 1); endtask

   task automatic set_date(int d, int mo, int y, int lp);
      cyc(1, 4'h4, dword(d, mo, y, lp), 0); pulse();
   endtask

   task automatic last_second();
      cyc(1, 4'h8, tword(23, 59, 59), 0); pulse();
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      logic [31:0] v;
      void'($urandom(32'd1234));
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_mon = 0; m_yr = 0; m_leap = 0;
      pend_t = 0; pend_d = 0; stg_t = 0; stg_d = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_all("R1");

      // R7: write is staged, busy visible, value lands on pulse
      cyc(1, 4'h8, tword(23, 59, 58), 0);
      check_all("R7 staged");
      repeat (3) @(negedge clk);
      check_all("R3 idle");
      pulse(); check_all("R7 commit");
      pulse(); check_all("R2 sec");
      cyc(1, 4'h8, tword(5, 59, 59), 0); pulse(); pulse();
      check_all("R2 hour carry");

      // R8 and R9: date pending while time carries a day
      last_second();
      cyc(1, 4'h4, dword(28, 2, 5, 0), 0);
      check_all("R8 staged");
      pulse(); check_all("R8 commit over carry");
      // R5 common and leap February
      last_second(); pulse(); check_all("R5 feb28");
      set_date(28, 2, 8, 1); last_second(); pulse(); check_all("R5 leap feb28");
      pulse(); last_second(); pulse(); check_all("R5 leap feb29");
      // R4 30 and 31 day months
      set_date(30, 4, 1, 0); last_second(); pulse(); check_all("R4 apr30");
      set_date(30, 1, 1, 0); last_second(); pulse(); check_all("R4 jan30");
      // R6 year wrap, leap kept
      set_date(31, 12, 63, 1); last_second(); pulse(); check_all("R6 year wrap");
      // R9 pending time write, carry from old value
      set_date(10, 3, 2, 0); last_second();
      cyc(1, 4'h8, tword(10, 20, 30), 0);
      pulse(); check_all("R9 carry kept");
      // R11 write in pulse cycle
      cyc(1, 4'h8, tword(1, 2, 3), 1);
      check_all("R11 still pending");
      pulse(); check_all("R11 commit");
      // R10 ignored writes
      cyc(1, 4'h0, 32'hFFFF_FFFF, 0);
      cyc(1, 4'hC, 32'hFFFF_FFFF, 0);
      check_all("R10 ignored");
      rd(4'hC, v); check("R10 unmapped read", v, 32'h0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 9);
         if (op <= 5) begin
            pulse(); check_all("R2 rand pulse");
         end else if (op == 6 || op == 9) begin
            logic [31:0] t = tword($urandom_range(20, 23), $urandom_range(55, 59),
                                   $urandom_range(50, 59));
            cyc(1, 4'h8, t, op == 9); check_all("R7 rand time");
         end else begin
            int mo = $urandom_range(1, 12);
            logic [31:0] d = dword($urandom_range(27, 31), mo, $urandom_range(0, 63),
                                   $urandom_range(0, 1));
            cyc(1, 4'h4, d, op == 8); check_all("R8 rand date");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule